// File: doc/BRIEF.md
# Calibrated Channel-Group Summer

This block takes sixteen parallel 14-bit ADC samples on every clock, where one clock is one sample period. For each channel it removes a pedestal, applies a fine gain weight, and then adds the calibrated channels into trigger sums. A mode register chooses the grouping. It can form four sums of four adjacent channels, or two sums of eight adjacent channels. Each sum is formed at 18-bit precision and is then cut down to a 16-bit word, ready for a serial link to a trigger processor.

A pedestal value and a gain code are kept for each channel. Both are loaded through a small write port, normally at start-up. One write carries the pedestal and the gain of one channel together. A write made while data is streaming changes that channel at a clean sample boundary. The pipeline accepts a new sample set on every clock and never stalls.

Top module: `grp_sum_calib`

## Requirements
- R1: Reset clears every output sum to zero, sets every pedestal to 0, sets every gain code to 128 (weight exactly 1.0), and selects the two-by-eight grouping.
- R2: A sample set applied before clock edge E produces its sums on the output after edge E+2. A new result appears after every edge, and an all-zero sample set gives all-zero sums.
- R3: Each channel value is computed as sample minus pedestal. When the pedestal exceeds the sample, the value is clamped to 0.
- R4: The weighted channel value is floor(d * (384 + g) / 512), where d is the clamped difference and g is the 8-bit gain code. Code 0 gives a weight of 0.75 and code 255 gives a weight of 639/512.
- R5: With mode_sel = 1 (four-by-four), output sum k, taken from sums bits [16k+15:16k], is built from channels 4k to 4k+3.
- R6: With mode_sel = 0 (two-by-eight), sum 0 is built from channels 0 to 7 and sum 1 from channels 8 to 15. Sums 2 and 3 are held at zero.
- R7: Each output word is the 18-bit group total with its two least significant bits dropped. A total that exceeds the 18-bit range is output as 0xFFFF.
- R8: A write with cfg_we = 1 to channel cfg_addr replaces that channel's pedestal and gain together at the clock edge where it is taken. The sample captured at that same edge still uses the old pair. Every later sample uses the new pair.
- R9: A write with mode_we = 1 replaces the grouping for samples captured after that edge. Sample sets already inside the pipeline keep the grouping they were captured with.
- R10: A table write changes only the addressed channel. The entries of all other channels keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; one edge per sample period |
| rst | input | 1 | Synchronous active-high reset |
| adc_data | input | 224 | Sixteen 14-bit samples; channel c occupies bits [14c+13:14c] |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | 4 | Channel index of the table write |
| cfg_ped | input | 14 | Pedestal value to store |
| cfg_gain | input | 8 | Gain code to store |
| mode_we | input | 1 | Grouping register write strobe |
| mode_sel | input | 1 | New grouping: 0 selects two-by-eight, 1 selects four-by-four |
| sums | output | 64 | Four 16-bit sums; sum k occupies bits [16k+15:16k] |

## Verification
A table write or a grouping change can land on the same clock edge as a sample capture, and the pipeline must then use the old setting for that sample and the new one for the next. The bench provokes this by issuing table writes and mode flips in the middle of back-to-back random sample streams, with no idle cycle around them. Its reference model computes each expectation from the settings that were in force before the write of that cycle is applied. Any off-by-one in the point where a change takes effect therefore shows up as a mismatch in one of the two neighbouring result words.

// File: rtl/grp_sum_pkg.sv
package grp_sum_pkg;

  // Grouping of calibrated channels into trigger sums
  typedef enum logic {
    GRP_2X8 = 1'b0,
    GRP_4X4 = 1'b1
  } grp_mode_e;

endpackage

// File: rtl/gsc_table.sv
// Per-channel pedestal/gain store plus grouping register.
// One write updates a channel's pedestal and gain together.
module gsc_table
  import grp_sum_pkg::*;
#(
  parameter int NCH = 16,
  parameter int DW  = 14,
  parameter int GW  = 8,
  localparam int AW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     ped_in,
  input  logic [GW-1:0]     gain_in,
  input  logic              mode_we,
  input  grp_mode_e         mode_in,
  output logic [NCH*DW-1:0] ped_flat,
  output logic [NCH*GW-1:0] gain_flat,
  output grp_mode_e         mode_q
);

  localparam logic [GW-1:0] GAIN_UNITY = GW'(1 << (GW-1));

  logic [DW-1:0] ped_r  [NCH];
  logic [GW-1:0] gain_r [NCH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin
        ped_r[i]  <= '0;
        gain_r[i] <= GAIN_UNITY;
      end
      mode_q <= GRP_2X8;
    end else begin
      if (we && (32'(addr) < NCH)) begin
        ped_r[addr]  <= ped_in;
        gain_r[addr] <= gain_in;
      end
      if (mode_we) mode_q <= mode_in;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_flat
    assign ped_flat[c*DW +: DW]  = ped_r[c];
    assign gain_flat[c*GW +: GW] = gain_r[c];
  end

endmodule

// File: rtl/gsc_chan.sv
// One channel: stage 1 subtracts and clamps, stage 2 applies the gain weight.
module gsc_chan #(
  parameter int DW = 14,
  parameter int GW = 8,
  localparam int PW = DW + 1,
  localparam int FW = GW + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] sample,
  input  logic [DW-1:0] ped,
  input  logic [GW-1:0] gain,
  output logic [DW-1:0] diff_q,
  output logic [PW-1:0] prod_q
);

  // weight = (BASE + code) / 2^(GW+1), BASE = 0.75 * 2^(GW+1)
  localparam logic [FW-1:0] BASE = FW'(3 << (GW-1));

  logic [DW:0]      diff_w;
  logic [GW-1:0]    gain_q;
  logic [FW-1:0]    factor_w;
  logic [DW+FW-1:0] mul_w;

  assign diff_w   = {1'b0, sample} - {1'b0, ped};
  assign factor_w = BASE + {2'b00, gain_q};
  assign mul_w    = {{FW{1'b0}}, diff_q} * {{DW{1'b0}}, factor_w};

  always_ff @(posedge clk) begin
    if (rst) begin
      diff_q <= '0;
      gain_q <= '0;
      prod_q <= '0;
    end else begin
      diff_q <= diff_w[DW] ? '0 : diff_w[DW-1:0];
      gain_q <= gain;
      prod_q <= mul_w[GW+1 +: PW];
    end
  end

endmodule

// File: rtl/gsc_adder.sv
// Stage 3: quad totals, optional pairing into octets, reduction to output width.
module gsc_adder
  import grp_sum_pkg::*;
#(
  parameter int NCH = 16,
  parameter int PW  = 15,
  parameter int SW  = 18,
  parameter int OW  = 16,
  localparam int NSUM = NCH / 4,
  localparam int XW   = SW + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NCH*PW-1:0]  prod_flat,
  input  grp_mode_e          mode,
  output logic [NSUM*OW-1:0] sums
);

  localparam logic [XW-1:0] LIM = XW'((1 << SW) - 1);

  logic [XW-1:0] quad [NSUM];
  logic [XW-1:0] pick [NSUM];

  always_comb begin
    for (int k = 0; k < NSUM; k++) begin
      quad[k] = '0;
      for (int j = 0; j < 4; j++) begin
        quad[k] = quad[k] + XW'(prod_flat[(4*k+j)*PW +: PW]);
      end
    end
  end

  for (genvar k = 0; k < NSUM; k++) begin : g_pick
    if (k < NSUM/2) begin : g_lo
      assign pick[k] = (mode == GRP_4X4) ? quad[k] : quad[2*k] + quad[2*k+1];
    end else begin : g_hi
      assign pick[k] = (mode == GRP_4X4) ? quad[k] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sums <= '0;
    end else begin
      for (int k = 0; k < NSUM; k++) begin
        if (pick[k] > LIM) sums[k*OW +: OW] <= '1;
        else               sums[k*OW +: OW] <= pick[k][SW-1 -: OW];
      end
    end
  end

endmodule

// File: rtl/grp_sum_calib.sv
// Top: calibrated channel-group summer, three-clock pipeline.
module grp_sum_calib
  import grp_sum_pkg::*;
#(
  parameter int NCH = 16,
  parameter int DW  = 14,
  parameter int GW  = 8,
  parameter int SW  = 18,
  parameter int OW  = 16,
  localparam int AW   = $clog2(NCH),
  localparam int NSUM = NCH / 4,
  localparam int PW   = DW + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NCH*DW-1:0]  adc_data,
  input  logic               cfg_we,
  input  logic [AW-1:0]      cfg_addr,
  input  logic [DW-1:0]      cfg_ped,
  input  logic [GW-1:0]      cfg_gain,
  input  logic               mode_we,
  input  logic               mode_sel,
  output logic [NSUM*OW-1:0] sums
);

  logic [NCH*DW-1:0] ped_flat;
  logic [NCH*GW-1:0] gain_flat;
  logic [NCH*DW-1:0] diff_flat;
  logic [NCH*PW-1:0] prod_flat;
  grp_mode_e         mode_q, mode_p1, mode_p2;

  gsc_table #(.NCH(NCH), .DW(DW), .GW(GW)) u_table (
    .clk       (clk),
    .rst       (rst),
    .we        (cfg_we),
    .addr      (cfg_addr),
    .ped_in    (cfg_ped),
    .gain_in   (cfg_gain),
    .mode_we   (mode_we),
    .mode_in   (grp_mode_e'(mode_sel)),
    .ped_flat  (ped_flat),
    .gain_flat (gain_flat),
    .mode_q    (mode_q)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    gsc_chan #(.DW(DW), .GW(GW)) u_chan (
      .clk    (clk),
      .rst    (rst),
      .sample (adc_data[c*DW +: DW]),
      .ped    (ped_flat[c*DW +: DW]),
      .gain   (gain_flat[c*GW +: GW]),
      .diff_q (diff_flat[c*DW +: DW]),
      .prod_q (prod_flat[c*PW +: PW])
    );
  end

  // grouping travels with its sample set
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_p1 <= GRP_2X8;
      mode_p2 <= GRP_2X8;
    end else begin
      mode_p1 <= mode_q;
      mode_p2 <= mode_p1;
    end
  end

  gsc_adder #(.NCH(NCH), .PW(PW), .SW(SW), .OW(OW)) u_adder (
    .clk       (clk),
    .rst       (rst),
    .prod_flat (prod_flat),
    .mode      (mode_p2),
    .sums      (sums)
  );

endmodule

// File: rtl/gsc_chk.sv
module gsc_chk #(
  parameter int NCH = 16,
  parameter int DW  = 14,
  parameter int PW  = 15,
  parameter int OW  = 16,
  localparam int NSUM = NCH / 4
) (
  input logic               clk,
  input logic               rst,
  input logic [NCH*DW-1:0]  adc_data,
  input logic [NCH*DW-1:0]  diff_flat,
  input logic [NCH*PW-1:0]  prod_flat,
  input logic               mode_p2,
  input logic [NSUM*OW-1:0] sums
);

  logic [1:0] since;
  always_ff @(posedge clk) begin
    if (rst)               since <= 2'd0;
    else if (since != 2'd3) since <= since + 2'd1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (sums == '0));

  // R2
  zero_in_chk: assert property (@(posedge clk) disable iff (rst)
    (since == 2'd3 && $past(adc_data, 3) == '0) |-> (sums == '0));

  // R6
  upper_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (since >= 2'd2 && mode_p2 == 1'b0) |=> (sums[NSUM*OW-1 : (NSUM/2)*OW] == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_c
    // R3
    clamp_chk: assert property (@(posedge clk) disable iff (rst)
      (since >= 2'd1) |-> (diff_flat[c*DW +: DW] <= $past(adc_data[c*DW +: DW])));

    // R4
    gain_low_chk: assert property (@(posedge clk) disable iff (rst)
      (since >= 2'd2) |->
        (32'(prod_flat[c*PW +: PW]) * 4 + 3 >= 32'($past(diff_flat[c*DW +: DW])) * 3));

    // R4
    gain_high_chk: assert property (@(posedge clk) disable iff (rst)
      (since >= 2'd2) |->
        (32'(prod_flat[c*PW +: PW]) * 4 <= 32'($past(diff_flat[c*DW +: DW])) * 5));
  end

endmodule

bind grp_sum_calib gsc_chk #(.NCH(NCH), .DW(DW), .PW(PW), .OW(OW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .adc_data  (adc_data),
  .diff_flat (diff_flat),
  .prod_flat (prod_flat),
  .mode_p2   (mode_p2),
  .sums      (sums)
);

// File: tb/grp_sum_calib_test.sv
module grp_sum_calib_test;

  localparam int NCH  = 16;
  localparam int DW   = 14;
  localparam int GW   = 8;
  localparam int OW   = 16;
  localparam int NSUM = NCH / 4;
  localparam int AW   = $clog2(NCH);

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [NCH*DW-1:0]  adc_data = '0;
  logic               cfg_we = 1'b0;
  logic [AW-1:0]      cfg_addr = '0;
  logic [DW-1:0]      cfg_ped = '0;
  logic [GW-1:0]      cfg_gain = '0;
  logic               mode_we = 1'b0;
  logic               mode_sel = 1'b0;
  logic [NSUM*OW-1:0] sums;

  grp_sum_calib uut (
    .clk(clk), .rst(rst), .adc_data(adc_data), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_ped(cfg_ped), .cfg_gain(cfg_gain),
    .mode_we(mode_we), .mode_sel(mode_sel), .sums(sums)
  );

  always #4 clk = ~clk;   // 125 MHz

  typedef struct {
    logic [NSUM*OW-1:0] exp;
    int                 due;
    string              tag;
  } item_t;

  item_t q[$];
  int    edge_cnt = 0;
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  int    m_ped  [NCH];
  int    m_gain [NCH];
  bit    m_mode;

  always @(posedge clk) edge_cnt++;

  // reference model built from the requirements
  function automatic logic [NSUM*OW-1:0] model(input logic [NCH*DW-1:0] a);
    longint p [NCH];
    longint s, d;
    logic [NSUM*OW-1:0] r = '0;
    for (int c = 0; c < NCH; c++) begin
      d = longint'(a[c*DW +: DW]) - m_ped[c];
      if (d < 0) d = 0;
      p[c] = (d * (384 + m_gain[c])) / 512;
    end
    for (int k = 0; k < NSUM; k++) begin
      s = 0;
      if (m_mode) begin
        for (int j = 0; j < 4; j++) s += p[4*k+j];
      end else if (k < NSUM/2) begin
        for (int j = 0; j < 8; j++) s += p[8*k+j];
      end
      s = s / 4;
      if (s > 65535) s = 65535;
      r[k*OW +: OW] = OW'(s);
    end
    return r;
  endfunction

  function automatic logic [NCH*DW-1:0] rnd(input int hi);
    logic [NCH*DW-1:0] r;
    for (int c = 0; c < NCH; c++) r[c*DW +: DW] = DW'($urandom_range(hi, 0));
    return r;
  endfunction

  function automatic logic [NCH*DW-1:0] fill(input int v);
    logic [NCH*DW-1:0] r;
    for (int c = 0; c < NCH; c++) r[c*DW +: DW] = DW'(v);
    return r;
  endfunction

  // driver: one sample set per cycle, optional writes in the same cycle
  task automatic cyc(input logic [NCH*DW-1:0] a, input string tag,
                     input bit we = 1'b0, input int addr = 0, input int ped = 0,
                     input int gain = 0, input bit mwe = 1'b0, input bit msel = 1'b0);
    item_t it;
    @(negedge clk); #2;
    adc_data = a;
    cfg_we   = we;
    cfg_addr = AW'(addr);
    cfg_ped  = DW'(ped);
    cfg_gain = GW'(gain);
    mode_we  = mwe;
    mode_sel = msel;
    it.exp = model(a);          // settings before this cycle's write
    it.due = edge_cnt + 3;      // capture edge + 2
    it.tag = tag;
    q.push_back(it);
    if (we) begin
      m_ped[addr]  = ped;
      m_gain[addr] = gain;
    end
    if (mwe) m_mode = msel;
  endtask

  // monitor
  always @(negedge clk) begin
    item_t it;
    while (q.size() > 0 && q[0].due <= edge_cnt) begin
      it = q.pop_front();
      n_chk++;
      if (sums !== it.exp) begin
        n_bad++;
        $display("FAIL %s: sums=%h expected %h", it.tag, sums, it.exp);
      end
    end
  end

  task automatic direct_zero(input string tag);
    n_chk++;
    if (sums !== '0) begin
      n_bad++;
      $display("FAIL %s: sums=%h expected %h", tag, sums, {NSUM*OW{1'b0}});
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: pending=%0d expected 0", q.size());
    finish_run();
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      m_ped[c]  = 0;
      m_gain[c] = 128;
    end
    m_mode = 1'b0;

    adc_data = fill(5000);
    repeat (4) @(posedge clk);
    @(negedge clk);
    direct_zero("R1 during reset");
    #2 adc_data = '0;
    rst = 1'b0;
    repeat (2) @(negedge clk);
    direct_zero("R1 after reset");

    // defaults: pedestal 0, unity weight, two-by-eight
    for (int i = 0; i < 16; i++) cyc(rnd(16383), "R1/R2 default tables");

    // table writes interleaved with streaming samples
    for (int c = 0; c < NCH; c++)
      cyc(rnd(16383), "R8 write mid-stream", 1'b1, c, 37*c + 50, (c*17) % 256);

    // low samples so many fall under their pedestal
    for (int i = 0; i < 24; i++) cyc(rnd(700), "R3/R4 clamp and weight");

    // grouping flip with full pipeline
    cyc(rnd(16383), "R9 mode to 4x4", 1'b0, 0, 0, 0, 1'b1, 1'b1);
    for (int i = 0; i < 16; i++) cyc(rnd(16383), "R5 four-by-four sums");

    // kill channel 5 only
    cyc(fill(9000), "R10 single entry write", 1'b1, 5, 16383, 0);
    for (int i = 0; i < 6; i++) cyc(fill(9000), "R10 other channels untouched");

    // full scale
    for (int c = 0; c < NCH; c++)
      cyc(fill(16383), "R7 load max weight", 1'b1, c, 0, 255);
    for (int i = 0; i < 4; i++) cyc(fill(16383), "R7 full scale 4x4");
    cyc(fill(16383), "R9 mode to 2x8", 1'b0, 0, 0, 0, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) cyc(fill(16383), "R7 full scale 2x8");
    for (int i = 0; i < 12; i++) cyc(rnd(16383), "R6 two-by-eight upper idle");

    // minimum weight
    for (int c = 0; c < NCH; c++)
      cyc(rnd(16383), "R4 load code 0", 1'b1, c, 0, 0);
    for (int i = 0; i < 8; i++) cyc(rnd(16383), "R4 weight 0.75");

    for (int i = 0; i < 4; i++) cyc('0, "R2 zero input");

    while (q.size() > 0) @(posedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule